// File: doc/BRIEF.md
# Multiplexed Flash Bus Address Capture

This block sits on the device side of a NOR flash bus where the address and data share one 16-bit wire group. Every rising edge of the bus clock it samples the chip enable, output enable, write enable and address-valid strobes, all active-low. From these it works out which bus operation is in progress: reset, standby, upper or lower address latch, asynchronous read, write, or synchronous burst read. It then reports that operation, the 22-bit word address of the access, whether a burst is running, and whether the device should drive the shared bus.

The word address is made of a 6-bit upper register and a 16-bit lower register, and each half is loaded in its own latch cycle. On reset the upper half is set to all ones when the part is strapped as top-boot and to all zeros when it is strapped as bottom-boot. A host that only ever sends the low 16 address bits therefore still lands in the 64K-word region at the boot end of the array. A mode input selects synchronous burst operation. Reset returns the block to asynchronous operation. During a burst, every qualifying clock edge moves the address to the next word, across the whole 22-bit space.

Top module: `fbus_addr_capture`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the upper address to all ones if `boot_top` is 1 and to all zeros otherwise, and sets the lower address to 0. It also clears the burst flag and selects asynchronous mode. While `rst` is high, `op_code` is 2 (reset) and `dq_oe` is 0.
- R2: With `ce_n` high and `rst` low, `op_code` is 1 (standby) and `dq_oe` is 0, whatever the other strobes are.
- R3: An edge with `ce_n`=0, `avd_n`=0, `we_n`=1 and `oe_n`=0 is an upper latch (`op_code` 3). It loads `acc_addr[21:16]` from `adq_in[5:0]` and leaves `acc_addr[15:0]` unchanged.
- R4: An edge with `ce_n`=0, `avd_n`=0, `we_n`=1 and `oe_n`=1 is a lower latch (`op_code` 4). It loads `acc_addr[15:0]` from `adq_in` and keeps the upper bits. After a reset, a lower latch on its own therefore gives an address inside the boot-end 64K words.
- R5: In asynchronous mode, `ce_n`=0, `oe_n`=0, `we_n`=1 and `avd_n`=1 decode as a read (`op_code` 5), and `dq_oe` is 1.
- R6: `ce_n`=0, `we_n`=0, `oe_n`=1 decodes as a write (`op_code` 6), with `dq_oe` 0 and the address unchanged across the edge. With both `we_n` and `oe_n` low the operation is idle (`op_code` 0).
- R7: The mode register takes `sync_mode` only at edges where `ce_n` is high. In synchronous mode, with no burst running, a read-like strobe pattern decodes as idle (`op_code` 0).
- R8: In synchronous mode, a lower latch starts a burst. `burst_act` is 1 from the next cycle, and `acc_addr` is the latched start address.
- R9: While a burst runs, `ce_n`=0, `oe_n`=0, `we_n`=1 and `avd_n`=1 decode as a burst beat (`op_code` 7) with `dq_oe` 1. The edge advances `acc_addr` by one word, and 0x3FFFFF wraps to 0.
- R10: An edge with `ce_n` high, a reset, or an upper latch ends the burst. A lower latch during a burst restarts it at the newly latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high hardware reset |
| boot_top | input | 1 | Boot-side strap: 1 = top boot, 0 = bottom boot |
| sync_mode | input | 1 | Requested access mode: 1 = synchronous burst |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| adq_in | input | 16 | Shared address/data bus, input side |
| acc_addr | output | 22 | Current word address |
| op_code | output | 3 | Decoded operation (0 idle, 1 standby, 2 reset, 3 upper latch, 4 lower latch, 5 read, 6 write, 7 burst beat) |
| burst_act | output | 1 | A synchronous burst is running |
| dq_oe | output | 1 | Device drives the shared bus |

## Verification
The hardest state to reach from the ports is a burst that crosses the top of the word space: it needs synchronous mode, a set upper address and a lower latch all in place. The stimulus first selects synchronous mode during standby. It then latches 0x3F as the upper address and 0xFFFE as the lower address, and clocks four beats through the wrap from 0x3FFFFF to 0. It follows with a restart by a new lower latch in the middle of the burst, an end by chip enable, and a reset under the other boot strap.

// File: rtl/fbus_pkg.sv
package fbus_pkg;

    localparam int UPPER_W_DEF = 6;
    localparam int LOWER_W_DEF = 16;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_STANDBY  = 3'd1,
        OP_RESET    = 3'd2,
        OP_LATCH_HI = 3'd3,
        OP_LATCH_LO = 3'd4,
        OP_READ     = 3'd5,
        OP_WRITE    = 3'd6,
        OP_BURST    = 3'd7
    } fbus_op_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic avd_n;
    } fbus_ctl_t;

    function automatic logic op_drives_bus(input fbus_op_e op);
        return (op == OP_READ) || (op == OP_BURST);
    endfunction

endpackage

// File: rtl/fbus_op_decode.sv
module fbus_op_decode
    import fbus_pkg::*;
(
    input  logic      rst,
    input  fbus_ctl_t ctl,
    input  logic      burst_act,
    input  logic      sync_q,
    output fbus_op_e  op
);

    always_comb begin
        if (rst) begin
            op = OP_RESET;
        end else if (ctl.ce_n) begin
            op = OP_STANDBY;
        end else if (!ctl.avd_n && ctl.we_n) begin
            op = ctl.oe_n ? OP_LATCH_LO : OP_LATCH_HI;
        end else if (!ctl.we_n) begin
            op = ctl.oe_n ? OP_WRITE : OP_IDLE;
        end else if (!ctl.oe_n) begin
            if (burst_act)   op = OP_BURST;
            else if (sync_q) op = OP_IDLE;
            else             op = OP_READ;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/fbus_addr_reg.sv
module fbus_addr_reg #(
    parameter int UPPER_W = 6,
    parameter int LOWER_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       boot_top,
    input  logic                       ld_upper,
    input  logic                       ld_lower,
    input  logic                       advance,
    input  logic [LOWER_W-1:0]         din,
    output logic [UPPER_W+LOWER_W-1:0] addr
);

    localparam int ADDR_W = UPPER_W + LOWER_W;

    logic [UPPER_W-1:0] upper_q;
    logic [LOWER_W-1:0] lower_q;
    logic [ADDR_W-1:0]  next_word;

    assign addr      = {upper_q, lower_q};
    assign next_word = addr + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= {UPPER_W{boot_top}};
            lower_q <= '0;
        end else if (ld_upper) begin
            upper_q <= din[UPPER_W-1:0];
        end else if (ld_lower) begin
            lower_q <= din;
        end else if (advance) begin
            upper_q <= next_word[ADDR_W-1:LOWER_W];
            lower_q <= next_word[LOWER_W-1:0];
        end
    end

endmodule

// File: rtl/fbus_burst_ctl.sv
module fbus_burst_ctl
    import fbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_mode,
    input  fbus_op_e op,
    output logic     burst_act,
    output logic     sync_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            burst_act <= 1'b0;
        end else begin
            unique case (op)
                OP_STANDBY: begin
                    sync_q    <= sync_mode;
                    burst_act <= 1'b0;
                end
                OP_LATCH_HI: burst_act <= 1'b0;
                OP_LATCH_LO: burst_act <= sync_q;
                default:     burst_act <= burst_act;
            endcase
        end
    end

endmodule

// File: rtl/fbus_addr_capture.sv
module fbus_addr_capture
    import fbus_pkg::*;
#(
    parameter int UPPER_W = UPPER_W_DEF,
    parameter int LOWER_W = LOWER_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       boot_top,
    input  logic                       sync_mode,
    input  logic                       ce_n,
    input  logic                       oe_n,
    input  logic                       we_n,
    input  logic                       avd_n,
    input  logic [LOWER_W-1:0]         adq_in,
    output logic [UPPER_W+LOWER_W-1:0] acc_addr,
    output logic [2:0]                 op_code,
    output logic                       burst_act,
    output logic                       dq_oe
);

    fbus_ctl_t ctl;
    fbus_op_e  op;
    logic      sync_q;

    assign ctl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, avd_n: avd_n};

    fbus_op_decode dec_i (
        .rst       (rst),
        .ctl       (ctl),
        .burst_act (burst_act),
        .sync_q    (sync_q),
        .op        (op)
    );

    fbus_burst_ctl bctl_i (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (sync_mode),
        .op        (op),
        .burst_act (burst_act),
        .sync_q    (sync_q)
    );

    fbus_addr_reg #(
        .UPPER_W (UPPER_W),
        .LOWER_W (LOWER_W)
    ) areg_i (
        .clk      (clk),
        .rst      (rst),
        .boot_top (boot_top),
        .ld_upper (op == OP_LATCH_HI),
        .ld_lower (op == OP_LATCH_LO),
        .advance  (op == OP_BURST),
        .din      (adq_in),
        .addr     (acc_addr)
    );

    assign op_code = op;
    assign dq_oe   = op_drives_bus(op);

endmodule

// File: rtl/fbus_addr_capture_chk.sv
module fbus_addr_capture_chk #(
    parameter int UPPER_W = 6,
    parameter int LOWER_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       boot_top,
    input logic                       ce_n,
    input logic                       oe_n,
    input logic                       we_n,
    input logic                       avd_n,
    input logic [LOWER_W-1:0]         adq_in,
    input logic [UPPER_W+LOWER_W-1:0] acc_addr,
    input logic [2:0]                 op_code,
    input logic                       burst_act,
    input logic                       dq_oe,
    input logic                       sync_q
);

    localparam int ADDR_W = UPPER_W + LOWER_W;

    logic latch_hi, latch_lo;
    assign latch_hi = !ce_n && !avd_n && we_n && !oe_n;
    assign latch_lo = !ce_n && !avd_n && we_n && oe_n;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (acc_addr == {{UPPER_W{$past(boot_top)}}, {LOWER_W{1'b0}}}) && !burst_act);

    assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!dq_oe && op_code == 3'd1));

    assert_upper_latch_R3: assert property (@(posedge clk) disable iff (rst)
        latch_hi |=> (acc_addr[ADDR_W-1:LOWER_W] == $past(adq_in[UPPER_W-1:0]))
                     && (acc_addr[LOWER_W-1:0] == $past(acc_addr[LOWER_W-1:0])));

    assert_lower_latch_R4: assert property (@(posedge clk) disable iff (rst)
        latch_lo |=> (acc_addr[LOWER_W-1:0] == $past(adq_in))
                     && (acc_addr[ADDR_W-1:LOWER_W] == $past(acc_addr[ADDR_W-1:LOWER_W])));

    assert_write_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd6) |=> $stable(acc_addr));

    assert_burst_start_R8: assert property (@(posedge clk) disable iff (rst)
        (latch_lo && sync_q) |=> burst_act);

    assert_burst_step_R9: assert property (@(posedge clk) disable iff (rst)
        (op_code == 3'd7) |=> (acc_addr == ADDR_W'($past(acc_addr) + 1'b1)));

    assert_burst_end_R10: assert property (@(posedge clk) disable iff (rst)
        (ce_n || latch_hi) |=> !burst_act);

endmodule

bind fbus_addr_capture fbus_addr_capture_chk #(
    .UPPER_W (UPPER_W),
    .LOWER_W (LOWER_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .boot_top  (boot_top),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .avd_n     (avd_n),
    .adq_in    (adq_in),
    .acc_addr  (acc_addr),
    .op_code   (op_code),
    .burst_act (burst_act),
    .dq_oe     (dq_oe),
    .sync_q    (sync_q)
);

// File: tb/fbus_addr_capture_tb.sv
`timescale 1ns/1ps
module fbus_addr_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_top = 1'b1;
    logic        sync_mode = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, avd_n = 1'b1;
    logic [15:0] adq_in = '0;
    logic [21:0] acc_addr;
    logic [2:0]  op_code;
    logic        burst_act, dq_oe;

    always #2.5 clk = ~clk;

    fbus_addr_capture dut_i (
        .clk(clk), .rst(rst), .boot_top(boot_top), .sync_mode(sync_mode),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .avd_n(avd_n), .adq_in(adq_in),
        .acc_addr(acc_addr), .op_code(op_code), .burst_act(burst_act), .dq_oe(dq_oe)
    );

    typedef struct {
        logic [21:0] addr;
        logic [2:0]  op;
        logic        burst;
        logic        oe;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Reference state built from the requirements (starts in top-boot reset state).
    logic [5:0]  m_upper = 6'h3F;
    logic [15:0] m_lower = '0;
    logic        m_burst = 1'b0;
    logic        m_mode  = 1'b0;

    function automatic logic [2:0] model_op(input logic r, c, o, w, a);
        if (r)            return 3'd2;
        if (c)            return 3'd1;
        if (!a && w)      return o ? 3'd4 : 3'd3;
        if (!w)           return o ? 3'd6 : 3'd0;
        if (!o)           return m_burst ? 3'd7 : (m_mode ? 3'd0 : 3'd5);
        return 3'd0;
    endfunction

    task automatic step(input logic r, c, o, w, a, s, b, input logic [15:0] d, input string tag);
        exp_t e;
        logic [2:0]  opx;
        logic [21:0] nxt;
        @(negedge clk);
        rst = r; ce_n = c; oe_n = o; we_n = w; avd_n = a;
        sync_mode = s; boot_top = b; adq_in = d;
        opx     = model_op(r, c, o, w, a);
        e.addr  = {m_upper, m_lower};
        e.op    = opx;
        e.burst = m_burst;
        e.oe    = (opx == 3'd5) || (opx == 3'd7);
        e.tag   = tag;
        sb.push_back(e);
        if (r) begin
            m_upper = {6{b}}; m_lower = '0; m_burst = 0; m_mode = 0;
        end else begin
            case (opx)
                3'd1: begin m_burst = 0; m_mode = s; end
                3'd3: begin m_upper = d[5:0]; m_burst = 0; end
                3'd4: begin m_lower = d; m_burst = m_mode; end
                3'd7: begin nxt = {m_upper, m_lower} + 22'd1; {m_upper, m_lower} = nxt; end
                default: ;
            endcase
        end
    endtask

    // Monitor: compares outputs just before each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1.5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (acc_addr !== e.addr || op_code !== e.op ||
                    burst_act !== e.burst || dq_oe !== e.oe) begin
                    errors++;
                    $display("FAIL %s: got addr=%h op=%0d burst=%b oe=%b, expected addr=%h op=%0d burst=%b oe=%b",
                             e.tag, acc_addr, op_code, burst_act, dq_oe,
                             e.addr, e.op, e.burst, e.oe);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        //   rst ce oe we avd sync boot data
        step(1, 1, 1, 1, 1, 0, 1, 16'h0000, "R1 top-boot reset");
        step(0, 1, 0, 0, 0, 0, 1, 16'hAAAA, "R2 standby ignores strobes");
        step(0, 0, 1, 1, 0, 0, 1, 16'h1234, "R4 lower latch only");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R4 R5 boot-end async read");
        step(0, 0, 1, 0, 1, 0, 1, 16'h5555, "R6 write");
        step(0, 0, 1, 0, 0, 0, 1, 16'h7777, "R6 write with avd low");
        step(0, 0, 0, 0, 1, 0, 1, 16'h0000, "R6 we and oe both low idle");
        step(0, 0, 0, 1, 0, 0, 1, 16'h0015, "R3 upper latch");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R3 R5 read after upper latch");
        step(0, 0, 1, 1, 1, 1, 1, 16'h0000, "R7 sync ignored outside standby");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R7 still async read");
        step(0, 1, 1, 1, 1, 1, 1, 16'h0000, "R7 select sync in standby");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R7 sync mode no burst idle");
        step(0, 0, 0, 1, 0, 0, 1, 16'h003F, "R3 upper latch 0x3F");
        step(0, 0, 1, 1, 0, 0, 1, 16'hFFFE, "R8 burst start latch");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R8 R9 first beat");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R9 beat top word");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R9 wrap to zero");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R9 beat after wrap");
        step(0, 0, 1, 1, 1, 0, 1, 16'h0000, "R9 oe high holds");
        step(0, 0, 1, 1, 0, 0, 1, 16'h0100, "R10 restart latch");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R10 restarted beat");
        step(0, 0, 0, 1, 0, 0, 1, 16'h0002, "R10 upper latch ends burst");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R10 no burst after upper latch");
        step(0, 0, 1, 1, 0, 0, 1, 16'h0200, "R8 second burst start");
        step(0, 0, 0, 1, 1, 0, 1, 16'h0000, "R9 second burst beat");
        step(0, 1, 0, 1, 1, 1, 1, 16'h0000, "R2 R10 ce high ends burst");
        step(0, 0, 0, 1, 1, 1, 1, 16'h0000, "R10 no burst after standby");
        step(0, 0, 1, 1, 0, 1, 1, 16'h4000, "R8 third burst start");
        step(1, 0, 0, 1, 1, 1, 0, 16'h0000, "R1 R10 reset during burst");
        step(0, 0, 1, 1, 0, 0, 0, 16'h00AB, "R1 R4 bottom-boot lower latch");
        step(0, 0, 0, 1, 1, 0, 0, 16'h0000, "R1 R7 async after reset");
        step(0, 1, 1, 1, 1, 0, 0, 16'h0000, "R2 final standby");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule